// File: doc/BRIEF.md
# Expansion ROM Window Ownership Arbiter

This block decides, cycle by cycle, whether one emulated peripheral card may drive the shared 2 KB expansion ROM window at 0xC800–0xCFFF of a 6502-style host bus. Each card that has a slot ROM page (0xCn00–0xCnFF) takes the window when its own page is accessed. It gives the window back when any other slot's page is accessed, or when the host touches 0xCFFF. The card does not know its slot at build time. It reads the slot number from a slot-map input that may change while the system runs.

Ownership changes only at a bus-cycle strobe that arrives while phi0 is high, so transceiver noise during phi1 cannot take or drop the window. The block drives three outputs: a slot-ROM select, an expansion-ROM select and a bus output enable. These feed the card's ROM and data drivers. It carries no data path, so it has no valid/ready stream. All pins are plain control levels. The ROM contents sit outside the block.

Top module: `xrom_owner_arb`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first claim, the card does not own the window: `exp_rom_sel` and `bus_oe` stay low for window addresses.
- R2: `slot_rom_sel` is high exactly when `phi0` is high, `slot_id` is non-zero and `addr[15:8]` equals 0xC0 plus `slot_id`. A `slot_id` of 0 means the card is unassigned and never selects a page.
- R3: A strobe (`addr_stb` high with `phi0` high) at an address in the card's own page makes the card the owner from the next clock on.
- R4: A strobe at 0xCFFF releases ownership from the next clock on. `exp_rom_sel` is never high for address 0xCFFF, even when the card currently owns the window.
- R5: A strobe at any page 0xC100–0xC7FF whose page number differs from `slot_id` releases ownership from the next clock on.
- R6: Ownership does not change on a clock where `addr_stb` is low or `phi0` is low. While `phi0` is low, all three outputs are low.
- R7: `exp_rom_sel` is high exactly when `phi0` is high, the card owns the window and `addr` lies in 0xC800–0xCFFE.
- R8: `bus_oe` is high exactly when `phi0` is high, `rw_n` is high (read) and either select is high. It falls in the same cycle that `phi0` falls, and it stays low on writes.
- R9: The slot number is taken from `slot_id` at each strobe. After `slot_id` changes, the new page claims and the old page releases. Strobes at I/O space 0xC0xx, at RAM or at the window leave ownership unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock, much faster than the host bus |
| rst_n | input | 1 | Active-low system reset |
| phi0 | input | 1 | Host bus phase; high in the phase where the address is valid and data transfers |
| addr_stb | input | 1 | One-clock strobe per bus cycle marking a valid address |
| rw_n | input | 1 | Host read (1) / write (0) |
| addr | input | 16 | Host address bus |
| slot_id | input | 3 | Slot number assigned to this card at run time, 0 = unassigned |
| slot_rom_sel | output | 1 | Card's own slot ROM page is addressed |
| exp_rom_sel | output | 1 | Card owns the window and it is addressed (excluding 0xCFFF) |
| bus_oe | output | 1 | Card may drive the host data bus |

## Verification
The bench builds the block with its default 16-bit address and 3-bit slot number. This default exposes all seven slot pages, so claims and releases can be driven from neighbouring slots as well as from the card's own slot. The default slot width also makes slot 0 available as the unassigned case. Moving `slot_id` between 3, 5 and 0 during one run tests run-time learning of the slot number against fixed page decodes. Together these settings cover the 0xCFFF boundary, strobes gated by phi0, and write cycles.

// File: rtl/xwin_pkg.sv
package xwin_pkg;
  // Classification of one host address as seen by the arbiter
  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,  // RAM, I/O page or anything outside the ROM bank
    ACC_OWN     = 3'd1,  // this card's slot ROM page
    ACC_OTHER   = 3'd2,  // a different slot's ROM page
    ACC_WINDOW  = 3'd3,  // shared window, excluding the release address
    ACC_RELEASE = 3'd4   // the window's top byte, releases every owner
  } acc_kind_e;
endpackage

// File: rtl/xwin_decode.sv
module xwin_decode
  import xwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 3,
  parameter logic [3:0] ROM_BANK = 4'hC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SLOT_W-1:0] slot_id,
  output acc_kind_e         kind
);
  localparam int NUM_PAGES = (1 << SLOT_W) - 1;
  localparam logic [ADDR_W-1:0] RELEASE_ADDR = {ROM_BANK, {(ADDR_W-4){1'b1}}};

  logic [3:0] bank_nib;
  logic [3:0] page_nib;
  logic       in_bank;
  logic [NUM_PAGES:0] page_hit;
  logic       own_hit;
  logic       any_hit;

  assign bank_nib = addr[ADDR_W-1 -: 4];
  assign page_nib = addr[ADDR_W-5 -: 4];
  assign in_bank  = (bank_nib == ROM_BANK);

  // index 0 is the unassigned slot: it never matches a page
  assign page_hit[0] = 1'b0;
  for (genvar p = 1; p <= NUM_PAGES; p++) begin : g_page
    assign page_hit[p] = in_bank && (page_nib == 4'(p));
  end

  assign own_hit = page_hit[slot_id];
  assign any_hit = |page_hit;

  always_comb begin
    if (addr == RELEASE_ADDR)
      kind = ACC_RELEASE;
    else if (in_bank && page_nib[3])
      kind = ACC_WINDOW;
    else if (own_hit)
      kind = ACC_OWN;
    else if (any_hit)
      kind = ACC_OTHER;
    else
      kind = ACC_NONE;
  end
endmodule

// File: rtl/xwin_owner.sv
module xwin_owner
  import xwin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,     // strobe qualified by phi0
  input  acc_kind_e kind,
  output logic      owner_q
);
  logic owner_d;

  always_comb begin
    owner_d = owner_q;
    if (take) begin
      unique case (kind)
        ACC_OWN:                owner_d = 1'b1;
        ACC_OTHER, ACC_RELEASE: owner_d = 1'b0;
        default:                owner_d = owner_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= 1'b0;
    else        owner_q <= owner_d;
  end
endmodule

// File: rtl/xwin_drive.sv
module xwin_drive
  import xwin_pkg::*;
(
  input  logic      phi0,
  input  logic      rw_n,
  input  logic      owner_q,
  input  acc_kind_e kind,
  output logic      slot_rom_sel,
  output logic      exp_rom_sel,
  output logic      bus_oe
);
  // combinational so the enable collapses in the cycle phi0 falls
  assign slot_rom_sel = phi0 && (kind == ACC_OWN);
  assign exp_rom_sel  = phi0 && owner_q && (kind == ACC_WINDOW);
  assign bus_oe       = phi0 && rw_n && (slot_rom_sel || exp_rom_sel);
endmodule

// File: rtl/xrom_owner_arb.sv
module xrom_owner_arb
  import xwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 3,
  parameter logic [3:0] ROM_BANK = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi0,
  input  logic              addr_stb,
  input  logic              rw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SLOT_W-1:0] slot_id,
  output logic              slot_rom_sel,
  output logic              exp_rom_sel,
  output logic              bus_oe
);
  acc_kind_e kind;
  logic      take;
  logic      owner_q;

  assign take = addr_stb && phi0;

  xwin_decode #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .ROM_BANK(ROM_BANK)
  ) decode_i (
    .addr(addr), .slot_id(slot_id), .kind(kind)
  );

  xwin_owner owner_i (
    .clk(clk), .rst_n(rst_n), .take(take), .kind(kind), .owner_q(owner_q)
  );

  xwin_drive drive_i (
    .phi0(phi0), .rw_n(rw_n), .owner_q(owner_q), .kind(kind),
    .slot_rom_sel(slot_rom_sel), .exp_rom_sel(exp_rom_sel), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/xrom_owner_arb_chk.sv
module xrom_owner_arb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phi0,
  input logic        addr_stb,
  input logic        rw_n,
  input logic [15:0] addr,
  input logic [2:0]  slot_id,
  input logic        owner_q,
  input logic        slot_rom_sel,
  input logic        exp_rom_sel,
  input logic        bus_oe
);
  logic strobe_ok;
  logic own_page;
  logic other_page;
  assign strobe_ok  = addr_stb && phi0;
  assign own_page   = (slot_id != 3'd0) && (addr[15:8] == {5'b11000, slot_id});
  assign other_page = (addr[15:12] == 4'hC) && (addr[11:8] >= 4'd1) &&
                      (addr[11:8] <= 4'd7) && (addr[11:8] != {1'b0, slot_id});

  // R3
  claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ok && own_page |=> owner_q);
  // R4
  release_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ok && addr == 16'hCFFF |=> !owner_q);
  // R4
  top_byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 16'hCFFF |-> !exp_rom_sel);
  // R5
  release_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ok && other_page |=> !owner_q);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_ok |=> $stable(owner_q));
  // R6
  phi1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phi0 |-> !bus_oe && !exp_rom_sel && !slot_rom_sel);
  // R7
  window_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_rom_sel |-> owner_q && addr[15:11] == 5'b11001);
  // R8
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> phi0 && rw_n);
endmodule

bind xrom_owner_arb xrom_owner_arb_chk chk_i (
  .clk(clk), .rst_n(rst_n), .phi0(phi0), .addr_stb(addr_stb), .rw_n(rw_n),
  .addr(addr), .slot_id(slot_id), .owner_q(owner_q),
  .slot_rom_sel(slot_rom_sel), .exp_rom_sel(exp_rom_sel), .bus_oe(bus_oe)
);

// File: tb/xrom_owner_arb_tb_top.sv
module xrom_owner_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi0 = 1'b0;
  logic        addr_stb = 1'b0;
  logic        rw_n = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [2:0]  slot_id = 3'd0;
  logic        slot_rom_sel, exp_rom_sel, bus_oe;

  int tests = 0;
  int fails = 0;
  bit model_own = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xrom_owner_arb dut_i (
    .clk(clk), .rst_n(rst_n), .phi0(phi0), .addr_stb(addr_stb), .rw_n(rw_n),
    .addr(addr), .slot_id(slot_id), .slot_rom_sel(slot_rom_sel),
    .exp_rom_sel(exp_rom_sel), .bus_oe(bus_oe)
  );

  // behavioural reference: ownership flag updated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) model_own = 1'b0;
    else if (addr_stb && phi0) begin
      if (addr == 16'hCFFF) model_own = 1'b0;
      else if (addr[15:12] == 4'hC && addr[11:8] >= 1 && addr[11:8] <= 7)
        model_own = (slot_id != 0) && (int'(addr[11:8]) == int'(slot_id));
    end
  end

  // drive at falling edge, compare one ns before the next rising edge
  task automatic step(input logic [15:0] a, input bit rd, input bit ph,
                      input bit stb, input string tag);
    bit e_slot, e_exp, e_oe;
    @(negedge clk);
    addr = a; rw_n = rd; phi0 = ph; addr_stb = stb;
    #4;
    e_slot = ph && slot_id != 0 && a[15:8] == (8'hC0 + 8'(slot_id));
    e_exp  = ph && model_own && a >= 16'hC800 && a <= 16'hCFFE && rst_n;
    e_oe   = ph && rd && (e_slot || e_exp);
    tests++;
    if (slot_rom_sel !== e_slot || exp_rom_sel !== e_exp || bus_oe !== e_oe) begin
      fails++;
      $display("FAIL %s addr=%h: got slot=%b exp=%b oe=%b expected slot=%b exp=%b oe=%b",
               tag, a, slot_rom_sel, exp_rom_sel, bus_oe, e_slot, e_exp, e_oe);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    slot_id = 3'd3;
    step(16'hC800, 1, 1, 1, "R1 in reset");
    step(16'hC300, 1, 1, 1, "R1 claim ignored in reset");
    rst_n = 1'b1;
    step(16'hC800, 1, 1, 1, "R1 window before claim");
    step(16'hC300, 1, 1, 1, "R2 R3 claim own page");
    step(16'hC800, 1, 1, 1, "R3 R7 window owned");
    step(16'hCABC, 1, 0, 0, "R6 phi1 quiet");
    step(16'hC100, 1, 0, 1, "R6 strobe in phi1");
    step(16'hC100, 1, 1, 0, "R6 no strobe");
    step(16'hCFFE, 1, 1, 1, "R6 R7 still owned at top-1");
    step(16'hC900, 0, 1, 1, "R8 write no oe");
    step(16'hC900, 1, 1, 0, "R8 read oe");
    step(16'hC900, 1, 0, 0, "R8 oe drops with phi0");
    step(16'hC080, 1, 1, 1, "R9 io page no change");
    step(16'h1234, 1, 1, 1, "R9 ram no change");
    step(16'hC800, 1, 1, 1, "R9 still owned");
    step(16'hCFFF, 1, 1, 1, "R4 top byte not driven");
    step(16'hC800, 1, 1, 1, "R4 released");
    step(16'hC3FF, 1, 1, 1, "R3 reclaim");
    step(16'hCA00, 1, 1, 1, "R3 owned again");
    step(16'hC500, 1, 1, 1, "R5 other page");
    step(16'hCA00, 1, 1, 1, "R5 released");
    step(16'hC310, 0, 1, 1, "R3 claim by write");
    step(16'hC700, 1, 1, 1, "R5 slot 7 page");
    step(16'hCA00, 1, 1, 1, "R5 released by 7");
    slot_id = 3'd5;
    step(16'hC300, 1, 1, 1, "R9 old page no select");
    step(16'hC500, 1, 1, 1, "R9 new page claims");
    step(16'hCC00, 1, 1, 1, "R9 owned via new slot");
    step(16'hC300, 1, 1, 1, "R9 old page releases");
    step(16'hCC00, 1, 1, 1, "R9 released");
    slot_id = 3'd0;
    step(16'hC000, 1, 1, 1, "R2 unassigned io");
    step(16'hC500, 1, 1, 1, "R2 unassigned no claim");
    step(16'hC800, 1, 1, 1, "R2 unassigned no window");
    slot_id = 3'd1;
    step(16'hC1FF, 1, 1, 1, "R2 slot one claims");
    step(16'hCFFF, 1, 1, 0, "R4 top byte no strobe quiet");
    step(16'hC800, 1, 1, 1, "R7 owned after unstrobed top");
    @(negedge clk); rst_n = 1'b0;
    step(16'hC800, 1, 1, 1, "R1 reset clears");
    rst_n = 1'b1;
    step(16'hC800, 1, 1, 1, "R1 not owned after reset");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule